// File: doc/BRIEF.md
# Decoded Instruction Cache Controller

This block keeps a small direct-mapped store of already-decoded instructions for a fetch stage. The fetch stage presents a physical fetch address; one cycle later the block reports hit or miss together with the stored decode payload. It also reports how many bytes the decoder may consume from that address without leaving the 4096-byte page. On a miss the fetch stage runs its decoder. A successful decode is written back through the fill port. A failed decode, such as an instruction that runs past the page end, is not cached; its result is handed back through a one-entry side buffer instead.

Each entry is validated against a per-page stamp kept in an internal table. A stamp is a counter in its low bits and a fetch-mode field in its top bits. Any write into a page bumps that page's counter. A change of fetch mode for a page replaces its mode field. Either way, the entries decoded earlier from that page stop matching at once, without any scan of the array. A single invalidate-all command empties the array and returns every page stamp to zero. Two counters report hits and misses over a rolling window of lookups.

Top module: `decode_cache`

## Requirements
- R1: A lookup accepted on one clock edge is answered by `rsp_valid` on the next. `rsp_hit` is 1 only when the indexed entry holds the same physical address and a stamp equal to the page's stamp at lookup time. `rsp_stamp` returns that page stamp, and on a hit `rsp_payload` is the stored decode.
- R2: A lookup that misses marks its entry invalid. A lookup that misses on a colliding address therefore also makes a previously filled address miss.
- R3: A fill with `fill_ok`=1 writes the address, the page's current stamp and the payload into the indexed entry. The fill is echoed on the next cycle with `dlv_valid`=1, `dlv_side`=0 and the payload. A fill with `fill_ok`=0 leaves the entry invalid and is echoed with `dlv_side`=1, with the payload taken from the side buffer.
- R4: A page stamp is STAMP_W bits: the top MODE_W bits are the mode field and the rest are a counter. A write to any byte of a page adds one to its counter and leaves the mode field unchanged. The all-ones counter value is reserved as invalid and is skipped, so the counter goes from all-ones minus one to zero. Entries filled before the write then miss.
- R5: A mode update whose bits differ from the page's mode field replaces that field and keeps the counter. Entries filled under the old mode then miss. An update with equal bits leaves the stamp unchanged.
- R6: `inv_all` makes every entry miss and sets every page stamp to zero. A lookup in the same cycle as `inv_all` misses.
- R7: `rsp_len` is 15, or 4096 minus the address bits [11:0] when that is less than 15.
- R8: The entry index is the XOR of the address split into IDX_W-bit chunks, starting at bit 0. Addresses with equal index evict each other, and addresses with different index are held together.
- R9: Each lookup adds one to a STAT_W-bit lookup count and to `hit_cnt` or `miss_cnt`. The lookup that wraps the count to zero instead clears both counters and is not counted.
- R10: After reset `rsp_valid` and `dlv_valid` are 0, both counters are 0, every entry is invalid and every page stamp is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_paddr | input | PADDR_W | Physical fetch address of the lookup |
| rsp_valid | output | 1 | Lookup answer valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_payload | output | PAY_W | Stored decode payload |
| rsp_stamp | output | STAMP_W | Page stamp seen by the lookup |
| rsp_len | output | 4 | Bytes the decoder may consume |
| fill_valid | input | 1 | Decoder result present |
| fill_ok | input | 1 | Decode succeeded |
| fill_paddr | input | PADDR_W | Address the decode belongs to |
| fill_payload | input | PAY_W | Decode payload |
| dlv_valid | output | 1 | Decoder result echoed |
| dlv_side | output | 1 | Echo came from the side buffer |
| dlv_payload | output | PAY_W | Echoed payload |
| wr_valid | input | 1 | Store into code memory observed |
| wr_paddr | input | PADDR_W | Store address |
| mode_valid | input | 1 | Fetch-mode update for a page |
| mode_paddr | input | PADDR_W | Any address in that page |
| mode_bits | input | MODE_W | New fetch-mode bits |
| inv_all | input | 1 | Purge or flush everything |
| hit_cnt | output | STAT_W | Hits in the current window |
| miss_cnt | output | STAT_W | Misses in the current window |

## Verification
On every cycle the checker confirms several properties: answers arrive only one cycle after a request, a lookup that follows an invalidate never hits, the reserved counter value never appears in a returned stamp, and the byte count stays within 1 to 15. It also checks that decoder echoes carry the side-buffer flag of their fill and that the counters move only with an answer. Whether a particular entry should hit depends on the history of fills, stores, mode changes and colliding lookups. Only the bench's reference model of entries and page stamps can judge that, together with the exact counter wrap after 62 stores and the clearing of the statistics at the window boundary.

// File: rtl/dic_pkg.sv
`timescale 1ns/1ps
package dic_pkg;
  localparam int PAGE_BITS = 12;
  localparam int FETCH_MAX = 15;

  typedef logic [3:0] fetch_len_t;

  typedef enum logic {
    DLV_CACHE = 1'b0,
    DLV_SIDE  = 1'b1
  } dlv_src_e;

  // Bytes available to the decoder from a page offset.
  function automatic fetch_len_t fetch_len(input logic [PAGE_BITS-1:0] off);
    logic [PAGE_BITS:0] left;
    left = (PAGE_BITS+1)'(1 << PAGE_BITS) - {1'b0, off};
    if (left < (PAGE_BITS+1)'(FETCH_MAX)) return left[3:0];
    return fetch_len_t'(FETCH_MAX);
  endfunction
endpackage

// File: rtl/dic_stamp_table.sv
`timescale 1ns/1ps
module dic_stamp_table #(
  parameter int PADDR_W   = 16,
  parameter int PAGE_BITS = 12,
  parameter int STAMP_W   = 8,
  parameter int MODE_W    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inv_all,
  input  logic                          bump_valid,
  input  logic [PADDR_W-PAGE_BITS-1:0]  bump_page,
  input  logic                          mode_valid,
  input  logic [PADDR_W-PAGE_BITS-1:0]  mode_page,
  input  logic [MODE_W-1:0]             mode_bits,
  input  logic [PADDR_W-PAGE_BITS-1:0]  rd_a_page,
  output logic [STAMP_W-1:0]            rd_a_stamp,
  input  logic [PADDR_W-PAGE_BITS-1:0]  rd_b_page,
  output logic [STAMP_W-1:0]            rd_b_stamp
);
  localparam int PG_W  = PADDR_W - PAGE_BITS;
  localparam int PAGES = 1 << PG_W;
  localparam int CNT_W = STAMP_W - MODE_W;

  logic [STAMP_W-1:0] stamp_all [PAGES];

  function automatic logic [CNT_W-1:0] bump_cnt(input logic [CNT_W-1:0] c);
    logic [CNT_W-1:0] n;
    n = c + 1'b1;
    if (&n) n = '0;
    return n;
  endfunction

  for (genvar p = 0; p < PAGES; p++) begin : g_pg
    logic [STAMP_W-1:0] q;
    logic [STAMP_W-1:0] d;
    logic               en;
    logic               hit_b;
    logic               hit_m;

    assign hit_b = bump_valid && (bump_page == PG_W'(p));
    assign hit_m = mode_valid && (mode_page == PG_W'(p));
    assign en    = inv_all | hit_b | hit_m;

    always_comb begin
      d = q;
      if (hit_m && (q[STAMP_W-1 -: MODE_W] != mode_bits))
        d[STAMP_W-1 -: MODE_W] = mode_bits;
      if (hit_b)
        d[CNT_W-1:0] = bump_cnt(q[CNT_W-1:0]);
      if (inv_all)
        d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign stamp_all[p] = q;
  end

  assign rd_a_stamp = stamp_all[rd_a_page];
  assign rd_b_stamp = stamp_all[rd_b_page];
endmodule

// File: rtl/dic_entry_array.sv
`timescale 1ns/1ps
module dic_entry_array #(
  parameter int PADDR_W = 16,
  parameter int IDX_W   = 4,
  parameter int PAY_W   = 32,
  parameter int STAMP_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inv_all,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [PADDR_W-1:0] rd_addr,
  output logic [STAMP_W-1:0] rd_stamp,
  output logic [PAY_W-1:0]   rd_pay,
  input  logic               kill_valid,
  input  logic [IDX_W-1:0]   kill_idx,
  input  logic               fill_valid,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [PADDR_W-1:0] fill_addr,
  input  logic [STAMP_W-1:0] fill_stamp,
  input  logic [PAY_W-1:0]   fill_pay
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [STAMP_W-1:0] STAMP_INV = '1;

  logic [PADDR_W-1:0] addr_mem  [ENTRIES];
  logic [PAY_W-1:0]   pay_mem   [ENTRIES];
  logic [STAMP_W-1:0] stamp_all [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic [STAMP_W-1:0] q;
    logic [STAMP_W-1:0] d;
    logic               en;
    logic               sel_f;
    logic               sel_k;

    assign sel_f = fill_valid && (fill_idx == IDX_W'(e));
    assign sel_k = kill_valid && (kill_idx == IDX_W'(e));
    assign en    = inv_all | sel_f | sel_k;

    always_comb begin
      if (inv_all)    d = STAMP_INV;
      else if (sel_f) d = fill_stamp;
      else            d = STAMP_INV;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= STAMP_INV;
      else if (en) q <= d;
    end

    assign stamp_all[e] = q;
  end

  // Data storage needs no reset: a stamp of all ones never matches.
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      addr_mem[fill_idx] <= fill_addr;
      pay_mem[fill_idx]  <= fill_pay;
    end
  end

  assign rd_addr  = addr_mem[rd_idx];
  assign rd_pay   = pay_mem[rd_idx];
  assign rd_stamp = stamp_all[rd_idx];
endmodule

// File: rtl/dic_stats.sv
`timescale 1ns/1ps
module dic_stats #(
  parameter int STAT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              upd_hit,
  output logic [STAT_W-1:0] hit_cnt,
  output logic [STAT_W-1:0] miss_cnt
);
  logic [STAT_W-1:0] lk_q, lk_d, hit_q, hit_d, miss_q, miss_d;

  always_comb begin
    lk_d   = lk_q + 1'b1;
    hit_d  = hit_q;
    miss_d = miss_q;
    if (lk_d == '0) begin
      hit_d  = '0;
      miss_d = '0;
    end else if (upd_hit) begin
      hit_d  = hit_q + 1'b1;
    end else begin
      miss_d = miss_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q   <= '0;
      hit_q  <= '0;
      miss_q <= '0;
    end else if (upd) begin
      lk_q   <= lk_d;
      hit_q  <= hit_d;
      miss_q <= miss_d;
    end
  end

  assign hit_cnt  = hit_q;
  assign miss_cnt = miss_q;
endmodule

// File: rtl/decode_cache.sv
`timescale 1ns/1ps
module decode_cache
  import dic_pkg::*;
#(
  parameter int PADDR_W = 16,
  parameter int IDX_W   = 4,
  parameter int PAY_W   = 32,
  parameter int STAMP_W = 8,
  parameter int MODE_W  = 2,
  parameter int STAT_W  = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [PADDR_W-1:0] lk_paddr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [PAY_W-1:0]   rsp_payload,
  output logic [STAMP_W-1:0] rsp_stamp,
  output logic [3:0]         rsp_len,
  input  logic               fill_valid,
  input  logic               fill_ok,
  input  logic [PADDR_W-1:0] fill_paddr,
  input  logic [PAY_W-1:0]   fill_payload,
  output logic               dlv_valid,
  output logic               dlv_side,
  output logic [PAY_W-1:0]   dlv_payload,
  input  logic               wr_valid,
  input  logic [PADDR_W-1:0] wr_paddr,
  input  logic               mode_valid,
  input  logic [PADDR_W-1:0] mode_paddr,
  input  logic [MODE_W-1:0]  mode_bits,
  input  logic               inv_all,
  output logic [STAT_W-1:0]  hit_cnt,
  output logic [STAT_W-1:0]  miss_cnt
);
  localparam int PG_W = PADDR_W - PAGE_BITS;

  function automatic logic [IDX_W-1:0] fold_idx(input logic [PADDR_W-1:0] a);
    logic [IDX_W-1:0] f;
    f = '0;
    for (int i = 0; i < PADDR_W; i++) f[i % IDX_W] = f[i % IDX_W] ^ a[i];
    return f;
  endfunction

  logic [IDX_W-1:0]   lk_idx, fl_idx;
  logic [STAMP_W-1:0] pg_stamp_lk, pg_stamp_fl;
  logic [PADDR_W-1:0] ent_addr;
  logic [STAMP_W-1:0] ent_stamp;
  logic [PAY_W-1:0]   ent_pay;
  logic               lk_hit;
  logic               fill_wr;

  assign lk_idx  = fold_idx(lk_paddr);
  assign fl_idx  = fold_idx(fill_paddr);
  assign fill_wr = fill_valid && fill_ok;

  dic_stamp_table #(
    .PADDR_W(PADDR_W), .PAGE_BITS(PAGE_BITS), .STAMP_W(STAMP_W), .MODE_W(MODE_W)
  ) u_stamps (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_all    (inv_all),
    .bump_valid (wr_valid),
    .bump_page  (wr_paddr[PADDR_W-1 -: PG_W]),
    .mode_valid (mode_valid),
    .mode_page  (mode_paddr[PADDR_W-1 -: PG_W]),
    .mode_bits  (mode_bits),
    .rd_a_page  (lk_paddr[PADDR_W-1 -: PG_W]),
    .rd_a_stamp (pg_stamp_lk),
    .rd_b_page  (fill_paddr[PADDR_W-1 -: PG_W]),
    .rd_b_stamp (pg_stamp_fl)
  );

  assign lk_hit = lk_valid && !inv_all && (ent_addr == lk_paddr) &&
                  (ent_stamp == pg_stamp_lk);

  dic_entry_array #(
    .PADDR_W(PADDR_W), .IDX_W(IDX_W), .PAY_W(PAY_W), .STAMP_W(STAMP_W)
  ) u_array (
    .clk        (clk),
    .rst_n      (rst_n),
    .inv_all    (inv_all),
    .rd_idx     (lk_idx),
    .rd_addr    (ent_addr),
    .rd_stamp   (ent_stamp),
    .rd_pay     (ent_pay),
    .kill_valid (lk_valid && !lk_hit),
    .kill_idx   (lk_idx),
    .fill_valid (fill_wr),
    .fill_idx   (fl_idx),
    .fill_addr  (fill_paddr),
    .fill_stamp (pg_stamp_fl),
    .fill_pay   (fill_payload)
  );

  dic_stats #(.STAT_W(STAT_W)) u_stats (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd      (lk_valid),
    .upd_hit  (lk_hit),
    .hit_cnt  (hit_cnt),
    .miss_cnt (miss_cnt)
  );

  // Lookup answer register
  logic               rv_q, rh_q, rv_d, rh_d;
  logic [PAY_W-1:0]   rp_q, rp_d;
  logic [STAMP_W-1:0] rs_q, rs_d;
  fetch_len_t         rl_q, rl_d;

  always_comb begin
    rv_d = lk_valid;
    rh_d = lk_hit;
    rp_d = ent_pay;
    rs_d = pg_stamp_lk;
    rl_d = fetch_len(lk_paddr[PAGE_BITS-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rv_q <= 1'b0;
      rh_q <= 1'b0;
    end else begin
      rv_q <= rv_d;
      rh_q <= rh_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q <= '0;
      rs_q <= '0;
      rl_q <= '0;
    end else if (lk_valid) begin
      rp_q <= rp_d;
      rs_q <= rs_d;
      rl_q <= rl_d;
    end
  end

  assign rsp_valid   = rv_q;
  assign rsp_hit     = rh_q;
  assign rsp_payload = rp_q;
  assign rsp_stamp   = rs_q;
  assign rsp_len     = rl_q;

  // Decoder echo: cache path or side buffer
  logic             dv_q;
  dlv_src_e         src_q, src_d;
  logic [PAY_W-1:0] cp_q, side_q;

  assign src_d = fill_ok ? DLV_CACHE : DLV_SIDE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dv_q  <= 1'b0;
      src_q <= DLV_CACHE;
    end else begin
      dv_q  <= fill_valid;
      if (fill_valid) src_q <= src_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_q   <= '0;
      side_q <= '0;
    end else begin
      if (fill_wr)                 cp_q   <= fill_payload;
      if (fill_valid && !fill_ok)  side_q <= fill_payload;
    end
  end

  assign dlv_valid   = dv_q;
  assign dlv_side    = (src_q == DLV_SIDE);
  assign dlv_payload = (src_q == DLV_SIDE) ? side_q : cp_q;
endmodule

// File: rtl/decode_cache_chk.sv
`timescale 1ns/1ps
module decode_cache_chk #(
  parameter int STAMP_W = 8,
  parameter int MODE_W  = 2,
  parameter int STAT_W  = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               inv_all,
  input logic               fill_valid,
  input logic               fill_ok,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [STAMP_W-1:0] rsp_stamp,
  input logic [3:0]         rsp_len,
  input logic               dlv_valid,
  input logic               dlv_side,
  input logic [STAT_W-1:0]  hit_cnt,
  input logic [STAT_W-1:0]  miss_cnt
);
  localparam int CNT_W = STAMP_W - MODE_W;

  p_answer_follows_request_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(lk_valid));

  p_no_hit_without_answer_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit);

  p_echo_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> ($past(fill_valid) && (dlv_side == !$past(fill_ok))));

  p_counter_skips_reserved_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_stamp[CNT_W-1:0] != {CNT_W{1'b1}}));

  p_miss_after_invalidate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inv_all) && rsp_valid) |-> !rsp_hit);

  p_len_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_len >= 4'd1 && rsp_len <= 4'd15));

  p_stats_move_with_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> ($stable(hit_cnt) && $stable(miss_cnt)));
endmodule

bind decode_cache decode_cache_chk #(
  .STAMP_W(STAMP_W), .MODE_W(MODE_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/decode_cache_tb.sv
`timescale 1ns/1ps
module decode_cache_tb;
  localparam int AW = 16, IW = 4, PW = 32, SW = 8, MW = 2, STW = 5;
  localparam int NE = 1 << IW, NP = 1 << (AW - 12);

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 0, fill_valid = 0, fill_ok = 0, wr_valid = 0, mode_valid = 0, inv_all = 0;
  logic [AW-1:0] lk_paddr = '0, fill_paddr = '0, wr_paddr = '0, mode_paddr = '0;
  logic [PW-1:0] fill_payload = '0;
  logic [MW-1:0] mode_bits = '0;
  logic rsp_valid, rsp_hit, dlv_valid, dlv_side;
  logic [PW-1:0] rsp_payload, dlv_payload;
  logic [SW-1:0] rsp_stamp;
  logic [3:0] rsp_len;
  logic [STW-1:0] hit_cnt, miss_cnt;

  always #5 clk = ~clk;

  decode_cache #(.PADDR_W(AW), .IDX_W(IW), .PAY_W(PW), .STAMP_W(SW), .MODE_W(MW), .STAT_W(STW)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_paddr(lk_paddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_payload(rsp_payload),
    .rsp_stamp(rsp_stamp), .rsp_len(rsp_len),
    .fill_valid(fill_valid), .fill_ok(fill_ok), .fill_paddr(fill_paddr), .fill_payload(fill_payload),
    .dlv_valid(dlv_valid), .dlv_side(dlv_side), .dlv_payload(dlv_payload),
    .wr_valid(wr_valid), .wr_paddr(wr_paddr), .mode_valid(mode_valid), .mode_paddr(mode_paddr),
    .mode_bits(mode_bits), .inv_all(inv_all), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt));

  int n_chk = 0, n_fail = 0;
  logic [SW-1:0] m_pg [NP];
  logic [AW-1:0] m_addr [NE];
  logic [SW-1:0] m_est [NE];
  logic [PW-1:0] m_pay [NE];
  logic [STW-1:0] m_lk = '0, m_hit = '0, m_miss = '0;
  logic last_hit;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] bfold(input logic [AW-1:0] a);
    logic [IW-1:0] r = '0;
    for (int k = 0; k * IW < AW; k++) r = r ^ IW'(a >> (k * IW));
    return r;
  endfunction

  function automatic logic [3:0] blen(input logic [AW-1:0] a);
    int left = 4096 - int'(a[11:0]);
    return (left < 15) ? 4'(left) : 4'd15;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NP; i++) m_pg[i] = '0;
    for (int i = 0; i < NE; i++) begin m_est[i] = '1; m_addr[i] = '0; m_pay[i] = '0; end
  endtask

  task automatic lookup(input logic [AW-1:0] a, input string req);
    logic [IW-1:0] ix = bfold(a);
    logic [SW-1:0] st = m_pg[a[15:12]];
    logic eh = (m_addr[ix] == a) && (m_est[ix] == st);
    @(negedge clk); lk_valid = 1; lk_paddr = a;
    @(negedge clk); lk_valid = 0;
    if (!eh) m_est[ix] = '1;
    m_lk = m_lk + 1'b1;
    if (m_lk == '0) begin m_hit = '0; m_miss = '0; end
    else if (eh) m_hit = m_hit + 1'b1;
    else m_miss = m_miss + 1'b1;
    chk({req, " R1 valid"}, rsp_valid, 1);
    chk({req, " R1 hit"}, rsp_hit, eh);
    chk({req, " R1 stamp"}, rsp_stamp, st);
    if (eh) chk({req, " R1 payload"}, rsp_payload, m_pay[ix]);
    chk({req, " R7 len"}, rsp_len, blen(a));
    chk({req, " R9 hits"}, hit_cnt, m_hit);
    chk({req, " R9 misses"}, miss_cnt, m_miss);
    last_hit = eh;
  endtask

  task automatic fill(input logic [AW-1:0] a, input logic ok, input logic [PW-1:0] p, input string req);
    @(negedge clk); fill_valid = 1; fill_ok = ok; fill_paddr = a; fill_payload = p;
    @(negedge clk); fill_valid = 0;
    if (ok) begin
      m_addr[bfold(a)] = a; m_est[bfold(a)] = m_pg[a[15:12]]; m_pay[bfold(a)] = p;
    end
    chk({req, " R3 dlv_valid"}, dlv_valid, 1);
    chk({req, " R3 dlv_side"}, dlv_side, !ok);
    chk({req, " R3 dlv_payload"}, dlv_payload, p);
  endtask

  task automatic store(input logic [AW-1:0] a);
    logic [SW-1:0] s = m_pg[a[15:12]];
    logic [SW-MW-1:0] c = s[SW-MW-1:0] + 1'b1;
    if (&c) c = '0;
    @(negedge clk); wr_valid = 1; wr_paddr = a;
    @(negedge clk); wr_valid = 0;
    m_pg[a[15:12]] = {s[SW-1 -: MW], c};
  endtask

  task automatic set_mode(input logic [AW-1:0] a, input logic [MW-1:0] m);
    @(negedge clk); mode_valid = 1; mode_paddr = a; mode_bits = m;
    @(negedge clk); mode_valid = 0;
    m_pg[a[15:12]][SW-1 -: MW] = m;
  endtask

  task automatic invalidate();
    @(negedge clk); inv_all = 1;
    @(negedge clk); inv_all = 0;
    model_reset();
  endtask

  function automatic logic [AW-1:0] pick();
    case ($urandom % 8)
      0: return 16'h1234;  1: return 16'h1225;  2: return 16'h1FFA;  3: return 16'h2000;
      4: return 16'h2ABC;  5: return 16'h3FF3;  6: return 16'h3001;  default: return 16'h1100;
    endcase
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10: reset state
    chk("R10 rsp_valid", rsp_valid, 0);
    chk("R10 dlv_valid", dlv_valid, 0);
    chk("R10 hit_cnt", hit_cnt, 0);
    chk("R10 miss_cnt", miss_cnt, 0);
    lookup(16'h1234, "R10 first lookup");
    chk("R10 first miss", rsp_hit, 0);
    chk("R10 stamp zero", rsp_stamp, 0);

    // R1/R3: fill then hit
    fill(16'h1234, 1, 32'hCAFE0001, "R3 ok");
    lookup(16'h1234, "R1 refetch");
    chk("R1 hit expected", rsp_hit, 1);
    // R8: distinct index coexists, colliding index evicts
    fill(16'h2ABC, 1, 32'hCAFE0002, "R8 other");
    lookup(16'h1234, "R8 keep A");
    chk("R8 A still hits", rsp_hit, 1);
    fill(16'h1225, 1, 32'hCAFE0003, "R8 collide");
    lookup(16'h1234, "R8 evicted");
    chk("R8 A evicted", rsp_hit, 0);
    // R2: miss on colliding address invalidates
    fill(16'h1234, 1, 32'hCAFE0004, "R2 refill");
    lookup(16'h1225, "R2 colliding miss");
    lookup(16'h1234, "R2 after kill");
    chk("R2 A misses", rsp_hit, 0);
    // R3: failed decode not cached
    fill(16'h2000, 0, 32'hDEAD0005, "R3 fail");
    lookup(16'h2000, "R3 not cached");
    chk("R3 miss after fail", rsp_hit, 0);
    // R4: store makes entry stale
    fill(16'h2ABC, 1, 32'hCAFE0006, "R4 fill");
    store(16'h2FFF);
    lookup(16'h2ABC, "R4 stale");
    chk("R4 stale miss", rsp_hit, 0);
    // R5: mode change
    fill(16'h3001, 1, 32'hCAFE0007, "R5 fill");
    set_mode(16'h3500, 2'b00);
    lookup(16'h3001, "R5 same mode");
    chk("R5 same mode hits", rsp_hit, 1);
    set_mode(16'h3500, 2'b01);
    lookup(16'h3001, "R5 new mode");
    chk("R5 mode change miss", rsp_hit, 0);
    chk("R5 mode field", rsp_stamp, 8'h40);
    // R6: invalidate all
    fill(16'h1100, 1, 32'hCAFE0008, "R6 fill");
    invalidate();
    lookup(16'h1100, "R6 after inv");
    chk("R6 miss", rsp_hit, 0);
    lookup(16'h2ABC, "R6 stamp zero");
    chk("R6 stamp cleared", rsp_stamp, 0);
    // R4: counter wrap skipping reserved value
    set_mode(16'h5000, 2'b10);
    for (int i = 0; i < 62; i++) store(16'h5000 + 16'(i));
    lookup(16'h5010, "R4 top count");
    chk("R4 count 62", rsp_stamp, 8'hBE);
    store(16'h5FFF);
    lookup(16'h5010, "R4 wrapped");
    chk("R4 wrap to zero", rsp_stamp, 8'h80);
    // R7: page end lengths
    lookup(16'h6FF1, "R7 fifteen");
    chk("R7 len 15", rsp_len, 15);
    lookup(16'h6FF2, "R7 fourteen");
    chk("R7 len 14", rsp_len, 14);
    lookup(16'h6FFF, "R7 one");
    chk("R7 len 1", rsp_len, 1);
    // R9: window wrap clears counters
    while (m_lk != '1) lookup(16'h7000, "R9 fill window");
    lookup(16'h7000, "R9 wrap");
    chk("R9 hits cleared", hit_cnt, 0);
    chk("R9 misses cleared", miss_cnt, 0);

    // Random mix
    for (int it = 0; it < 600; it++) begin
      int r = $urandom % 10;
      if (r < 6) begin
        logic [AW-1:0] a = pick();
        lookup(a, "R1 random");
        if (!last_hit) fill(a, ($urandom % 6) != 0, $urandom, "R3 random");
      end else if (r < 8) store(pick() ^ 16'($urandom % 4096));
      else if (r == 8) set_mode(pick(), 2'($urandom));
      else if (($urandom % 5) == 0) invalidate();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule